// File: doc/BRIEF.md
# Block-Move Copy Sequencer

This block sequences the two block-move instructions of a CPU core that has a 16-bit register file and 24-bit addresses. Each instruction pass copies one byte. The pass fetches two bank operands from the instruction stream. It reads one byte from the source bank at offset X and holds that byte in an internal buffer. It writes the byte to the destination bank at offset Y. It then spends two idle bus cycles before it updates the count and index registers. The core repeats the instruction until the count is used up. The sequencer supports this by moving its program counter back onto the opcode, and the core fetches and issues the same instruction again.

The core starts a pass with a one-cycle start strobe. Along with the strobe it supplies the opcode byte and the current A, X, Y, program counter and program bank. The sequencer drives a single-port byte memory bus with a read strobe and a write strobe. At the end of the pass it pulses `done` and presents the updated registers. The `again` flag marks whether the core should issue the instruction once more.

Top module: `blkmove_seq`

## Requirements
- R1: A start strobe is accepted only while the block is idle and only with opcode 0x54 (incrementing) or 0x44 (decrementing). A strobe with any other opcode produces no bus activity and leaves `busy` low.
- R2: The first two bus cycles are reads at {program bank, PC} and then at {program bank, PC+1}. The first byte read is the destination bank and the second is the source bank. PC advances by one after each of these reads.
- R3: The third bus cycle is a read at {source bank, X}, and the byte read is held in the internal buffer.
- R4: The fourth bus cycle is a write of the buffered byte to {destination bank, Y}.
- R5: The fifth and sixth cycles place {destination bank, Y} on the address bus with both strobes low.
- R6: At the end of a pass, A is one less than before, with 16-bit wrap. X and Y both increase by one for 0x54 and both decrease by one for 0x44. They wrap modulo 2^16 and the banks are not affected.
- R7: If the decremented A is not 0xFFFF, the output PC equals the opcode address (the entry PC). Otherwise it equals the entry PC plus 3.
- R8: `done` is high for exactly one cycle, the cycle after the second idle cycle. `again` is high in that cycle exactly when the decremented A is not 0xFFFF, and it is low at all other times.
- R9: After a pass, the data-bank output holds the destination bank fetched by that pass.
- R10: After reset, `busy`, `done`, `again` and both strobes are low, and all register outputs are zero.
- R11: The read strobe and the write strobe are never high in the same cycle.
- R12: Repeating passes until `again` is low copies A+1 bytes in total, ascending for 0x54 and descending for 0x44.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one pass (sampled while idle) |
| opcode | input | 8 | Opcode byte of the instruction being issued |
| a_in | input | 16 | Count register value at issue |
| x_in | input | 16 | Source offset at issue |
| y_in | input | 16 | Destination offset at issue |
| pc_in | input | 16 | Address of the first operand byte |
| pbank_in | input | 8 | Program bank |
| mem_addr | output | 24 | Bus address {bank, offset} |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, sampled at the end of a read cycle |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| again | output | 1 | With done: the instruction must run again |
| a_out | output | 16 | Updated count |
| x_out | output | 16 | Updated source offset |
| y_out | output | 16 | Updated destination offset |
| pc_out | output | 16 | Updated program counter |
| dbank_out | output | 8 | Data bank register |

## Verification
Some properties are checked by assertions on every cycle. These are the exclusion between the two strobes, the single-cycle `done` pulse, that `again` can be high only together with `done`, that a write always follows a read, the count decrement, the three-byte PC rewind, and the loading of the data bank. The bench scenarios are needed for the rest: the exact address in each of the six bus cycles, that the written byte equals the byte read, that the index steps in the right direction and wraps, and that a whole repeated copy lands A+1 bytes in the right order.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;

    localparam int OFF_W_D  = 16;
    localparam int BANK_W_D = 8;
    localparam int DATA_W_D = 8;
    localparam int REWIND_D = 3;

    localparam logic [7:0] OPC_UP   = 8'h54;
    localparam logic [7:0] OPC_DOWN = 8'h44;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DBANK = 3'd1,
        PH_SBANK = 3'd2,
        PH_READ  = 3'd3,
        PH_WRITE = 3'd4,
        PH_IO1   = 3'd5,
        PH_IO2   = 3'd6
    } phase_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    function automatic logic is_move_op(input logic [7:0] op);
        return (op == OPC_UP) || (op == OPC_DOWN);
    endfunction

    function automatic dir_e op_dir(input logic [7:0] op);
        return (op == OPC_DOWN) ? DIR_DOWN : DIR_UP;
    endfunction

    function automatic logic [OFF_W_D-1:0] index_step(input logic [OFF_W_D-1:0] v,
                                                      input dir_e d);
        return (d == DIR_UP) ? v + 1'b1 : v - 1'b1;
    endfunction

endpackage

// File: rtl/blkmove_fsm.sv
module blkmove_fsm
    import blkmove_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] opcode,
    input  logic       more,
    output phase_e     phase,
    output dir_e       dir,
    output logic       accept,
    output logic       done,
    output logic       again
);

    phase_e ph_q, ph_d;
    dir_e   dir_q;
    logic   done_q, again_q;

    assign accept = start && (ph_q == PH_IDLE) && is_move_op(opcode);

    always_comb begin
        case (ph_q)
            PH_IDLE:  ph_d = accept ? PH_DBANK : PH_IDLE;
            PH_DBANK: ph_d = PH_SBANK;
            PH_SBANK: ph_d = PH_READ;
            PH_READ:  ph_d = PH_WRITE;
            PH_WRITE: ph_d = PH_IO1;
            PH_IO1:   ph_d = PH_IO2;
            PH_IO2:   ph_d = PH_IDLE;
            default:  ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            dir_q   <= DIR_UP;
            done_q  <= 1'b0;
            again_q <= 1'b0;
        end else begin
            ph_q    <= ph_d;
            if (accept) dir_q <= op_dir(opcode);
            done_q  <= (ph_q == PH_IO2);
            again_q <= (ph_q == PH_IO2) && more;
        end
    end

    assign phase = ph_q;
    assign dir   = dir_q;
    assign done  = done_q;
    assign again = again_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R8
    AST_AGAIN_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        again_q |-> done_q); // R8
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_WRITE) |-> ($past(ph_q) == PH_READ)); // R4

endmodule

// File: rtl/blkmove_regs.sv
module blkmove_regs
    import blkmove_pkg::*;
#(
    parameter int OFF_W  = OFF_W_D,
    parameter int BANK_W = BANK_W_D,
    parameter int DATA_W = DATA_W_D,
    parameter int REWIND = REWIND_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  phase_e            phase,
    input  dir_e              dir,
    input  logic [OFF_W-1:0]  a_in,
    input  logic [OFF_W-1:0]  x_in,
    input  logic [OFF_W-1:0]  y_in,
    input  logic [OFF_W-1:0]  pc_in,
    input  logic [BANK_W-1:0] pbank_in,
    input  logic [DATA_W-1:0] rdata,
    output logic [OFF_W-1:0]  a_q,
    output logic [OFF_W-1:0]  x_q,
    output logic [OFF_W-1:0]  y_q,
    output logic [OFF_W-1:0]  pc_q,
    output logic [BANK_W-1:0] pbank_q,
    output logic [BANK_W-1:0] dbank_q,
    output logic [BANK_W-1:0] sbank_q,
    output logic [BANK_W-1:0] dbr_q,
    output logic [DATA_W-1:0] buf_q,
    output logic              more
);

    localparam logic [OFF_W-1:0] REWIND_V = OFF_W'(REWIND);

    assign more = (a_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            x_q     <= '0;
            y_q     <= '0;
            pc_q    <= '0;
            pbank_q <= '0;
            dbank_q <= '0;
            sbank_q <= '0;
            dbr_q   <= '0;
            buf_q   <= '0;
        end else if (accept) begin
            a_q     <= a_in;
            x_q     <= x_in;
            y_q     <= y_in;
            pc_q    <= pc_in;
            pbank_q <= pbank_in;
        end else begin
            case (phase)
                PH_DBANK: begin
                    dbank_q <= BANK_W'(rdata);
                    pc_q    <= pc_q + 1'b1;
                end
                PH_SBANK: begin
                    sbank_q <= BANK_W'(rdata);
                    pc_q    <= pc_q + 1'b1;
                end
                PH_READ: buf_q <= rdata;
                PH_IO2: begin
                    a_q   <= a_q - 1'b1;
                    x_q   <= index_step(x_q, dir);
                    y_q   <= index_step(y_q, dir);
                    dbr_q <= dbank_q;
                    if (more) pc_q <= pc_q - REWIND_V;
                end
                default: ;
            endcase
        end
    end

    AST_COUNT_DEC: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IO2) |=> (a_q == OFF_W'($past(a_q) - 1'b1))); // R6
    AST_PC_REWIND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IO2 && more) |=> (pc_q == OFF_W'($past(pc_q) - REWIND_V))); // R7
    AST_PC_HOLD_LAST: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IO2 && !more) |=> $stable(pc_q)); // R7
    AST_DBR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IO2) |=> (dbr_q == $past(dbank_q))); // R9

endmodule

// File: rtl/blkmove_bus.sv
module blkmove_bus
    import blkmove_pkg::*;
#(
    parameter int OFF_W  = OFF_W_D,
    parameter int BANK_W = BANK_W_D,
    parameter int DATA_W = DATA_W_D,
    localparam int ADDR_W = OFF_W + BANK_W
) (
    input  phase_e            phase,
    input  logic [BANK_W-1:0] pbank,
    input  logic [BANK_W-1:0] dbank,
    input  logic [BANK_W-1:0] sbank,
    input  logic [OFF_W-1:0]  pc,
    input  logic [OFF_W-1:0]  x,
    input  logic [OFF_W-1:0]  y,
    input  logic [DATA_W-1:0] buf_data,
    output logic [ADDR_W-1:0] addr,
    output logic              rd,
    output logic              wr,
    output logic [DATA_W-1:0] wdata
);

    always_comb begin
        addr  = '0;
        rd    = 1'b0;
        wr    = 1'b0;
        wdata = '0;
        case (phase)
            PH_DBANK, PH_SBANK: begin
                addr = {pbank, pc};
                rd   = 1'b1;
            end
            PH_READ: begin
                addr = {sbank, x};
                rd   = 1'b1;
            end
            PH_WRITE: begin
                addr  = {dbank, y};
                wr    = 1'b1;
                wdata = buf_data;
            end
            PH_IO1, PH_IO2: addr = {dbank, y};
            default: ;
        endcase
    end

endmodule

// File: rtl/blkmove_seq.sv
module blkmove_seq
    import blkmove_pkg::*;
#(
    parameter int OFF_W  = OFF_W_D,
    parameter int BANK_W = BANK_W_D,
    parameter int DATA_W = DATA_W_D,
    parameter int REWIND = REWIND_D,
    localparam int ADDR_W = OFF_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [OFF_W-1:0]  a_in,
    input  logic [OFF_W-1:0]  x_in,
    input  logic [OFF_W-1:0]  y_in,
    input  logic [OFF_W-1:0]  pc_in,
    input  logic [BANK_W-1:0] pbank_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              again,
    output logic [OFF_W-1:0]  a_out,
    output logic [OFF_W-1:0]  x_out,
    output logic [OFF_W-1:0]  y_out,
    output logic [OFF_W-1:0]  pc_out,
    output logic [BANK_W-1:0] dbank_out
);

    phase_e            phase;
    dir_e              dir;
    logic              accept, more;
    logic [BANK_W-1:0] pbank_q, dbank_q, sbank_q;
    logic [DATA_W-1:0] buf_q;

    blkmove_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .opcode (opcode),
        .more   (more),
        .phase  (phase),
        .dir    (dir),
        .accept (accept),
        .done   (done),
        .again  (again)
    );

    blkmove_regs #(
        .OFF_W  (OFF_W),
        .BANK_W (BANK_W),
        .DATA_W (DATA_W),
        .REWIND (REWIND)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .phase    (phase),
        .dir      (dir),
        .a_in     (a_in),
        .x_in     (x_in),
        .y_in     (y_in),
        .pc_in    (pc_in),
        .pbank_in (pbank_in),
        .rdata    (mem_rdata),
        .a_q      (a_out),
        .x_q      (x_out),
        .y_q      (y_out),
        .pc_q     (pc_out),
        .pbank_q  (pbank_q),
        .dbank_q  (dbank_q),
        .sbank_q  (sbank_q),
        .dbr_q    (dbank_out),
        .buf_q    (buf_q),
        .more     (more)
    );

    blkmove_bus #(
        .OFF_W  (OFF_W),
        .BANK_W (BANK_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .phase    (phase),
        .pbank    (pbank_q),
        .dbank    (dbank_q),
        .sbank    (sbank_q),
        .pc       (pc_out),
        .x        (x_out),
        .y        (y_out),
        .buf_data (buf_q),
        .addr     (mem_addr),
        .rd       (mem_rd),
        .wr       (mem_wr),
        .wdata    (mem_wdata)
    );

    assign busy = (phase != PH_IDLE);

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !mem_wr)); // R1
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy)); // R8

endmodule

// File: tb/test_blkmove_seq.sv
module test_blkmove_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] a_in = '0, x_in = '0, y_in = '0, pc_in = '0;
    logic [7:0]  pbank_in = '0;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        busy, done, again;
    logic [15:0] a_out, x_out, y_out, pc_out;
    logic [7:0]  dbank_out;

    int vectors = 0;
    int miscompares = 0;

    logic [7:0] mem [0:4095];

    always #2 clk = ~clk;

    function automatic int idx(input logic [23:0] ad);
        return int'({ad[17:16], ad[15], ad[8:0]});
    endfunction

    assign mem_rdata = mem[idx(mem_addr)];

    always @(posedge clk) if (mem_wr) mem[idx(mem_addr)] <= mem_wdata;

    blkmove_seq i_blkmove_seq (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .a_in(a_in), .x_in(x_in), .y_in(y_in), .pc_in(pc_in), .pbank_in(pbank_in),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .again(again),
        .a_out(a_out), .x_out(x_out), .y_out(y_out), .pc_out(pc_out),
        .dbank_out(dbank_out)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_bus(input string req, input logic [23:0] ad,
                             input logic rd, input logic wr);
        chk(req, "addr", mem_addr, ad);
        chk(req, "rd",   mem_rd, rd);
        chk(req, "wr",   mem_wr, wr);
        chk(req, "busy", busy, 1);
    endtask

    // One pass; entered and left at a negedge.
    task automatic run_pass(input logic [7:0] op, input logic [7:0] pb,
                            inout logic [15:0] a, inout logic [15:0] x,
                            inout logic [15:0] y, inout logic [15:0] pc,
                            output logic rep);
        logic [7:0]  db, sb, bexp;
        logic [15:0] ex_a, ex_x, ex_y, ex_pc;
        db   = mem[idx({pb, pc})];
        sb   = mem[idx({pb, pc + 16'd1})];
        bexp = mem[idx({sb, x})];
        start = 1'b1; opcode = op; a_in = a; x_in = x; y_in = y; pc_in = pc; pbank_in = pb;
        @(negedge clk);
        start = 1'b0;
        check_bus("R2", {pb, pc}, 1, 0);
        @(negedge clk);
        check_bus("R2", {pb, pc + 16'd1}, 1, 0);
        @(negedge clk);
        check_bus("R3", {sb, x}, 1, 0);
        @(negedge clk);
        check_bus("R4", {db, y}, 0, 1);
        chk("R4", "wdata", mem_wdata, bexp);
        @(negedge clk);
        check_bus("R5", {db, y}, 0, 0);
        @(negedge clk);
        check_bus("R5", {db, y}, 0, 0);
        @(negedge clk);
        ex_a  = a - 16'd1;
        ex_x  = (op == 8'h54) ? x + 16'd1 : x - 16'd1;
        ex_y  = (op == 8'h54) ? y + 16'd1 : y - 16'd1;
        rep   = (ex_a != 16'hFFFF);
        ex_pc = rep ? pc - 16'd1 : pc + 16'd2;
        chk("R8", "done", done, 1);
        chk("R8", "again", again, rep);
        chk("R6", "a_out", a_out, ex_a);
        chk("R6", "x_out", x_out, ex_x);
        chk("R6", "y_out", y_out, ex_y);
        chk("R7", "pc_out", pc_out, ex_pc);
        chk("R9", "dbank_out", dbank_out, db);
        chk("R11", "strobes", {mem_rd, mem_wr}, 0);
        a = ex_a; x = ex_x; y = ex_y; pc = ex_pc;
    endtask

    task automatic run_move(input logic [7:0] op, input logic [7:0] pb, input logic [15:0] pc0,
                            input logic [7:0] db, input logic [7:0] sb,
                            input logic [15:0] a0, input logic [15:0] x0, input logic [15:0] y0);
        logic [7:0]  src_q[$];
        logic [15:0] a, x, y, pc, off_s, off_d;
        logic        rep;
        int          passes;
        mem[idx({pb, pc0 + 16'd1})] = db;
        mem[idx({pb, pc0 + 16'd2})] = sb;
        off_s = x0;
        for (int i = 0; i <= int'(a0); i++) begin
            src_q.push_back(mem[idx({sb, off_s})]);
            off_s = (op == 8'h54) ? off_s + 16'd1 : off_s - 16'd1;
        end
        a = a0; x = x0; y = y0; pc = pc0 + 16'd1;
        passes = 0;
        rep = 1'b1;
        while (rep && passes < 300) begin
            run_pass(op, pb, a, x, y, pc, rep);
            if (rep) chk("R7", "rewind to opcode", pc, pc0);
            pc = pc + 16'd1;
            passes++;
        end
        chk("R12", "pass count", passes, int'(a0) + 1);
        chk("R7", "final pc", pc_out, pc0 + 16'd3);
        off_d = y0;
        foreach (src_q[i]) begin
            chk("R12", "copied byte", mem[idx({db, off_d})], src_q[i]);
            off_d = (op == 8'h54) ? off_d + 16'd1 : off_d - 16'd1;
        end
    endtask

    task automatic try_ignored(input logic [7:0] op);
        start = 1'b1; opcode = op; a_in = 16'd5; pc_in = 16'h0301; pbank_in = 8'h00;
        @(negedge clk);
        start = 1'b0;
        chk("R1", "busy after bad opcode", busy, 0);
        chk("R1", "rd after bad opcode", mem_rd, 0);
        @(negedge clk);
        chk("R1", "done after bad opcode", done, 0);
        chk("R1", "wr after bad opcode", mem_wr, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL R8 watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 37 + 5) ^ (i >> 4));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "busy", busy, 0);
        chk("R10", "done", done, 0);
        chk("R10", "again", again, 0);
        chk("R10", "strobes", {mem_rd, mem_wr}, 0);
        chk("R10", "a_out", a_out, 0);
        chk("R10", "pc_out", pc_out, 0);
        chk("R10", "dbank_out", dbank_out, 0);

        try_ignored(8'hEA);
        try_ignored(8'h45);
        try_ignored(8'h55);

        // incrementing, four bytes
        run_move(8'h54, 8'h00, 16'h0100, 8'h02, 8'h01, 16'd3, 16'h0010, 16'h0040);
        // decrementing, three bytes
        run_move(8'h44, 8'h00, 16'h0200, 8'h03, 8'h01, 16'd2, 16'h0020, 16'h0080);
        // source offset wraps upward
        run_move(8'h54, 8'h00, 16'h0120, 8'h02, 8'h01, 16'd3, 16'hFFFE, 16'h0050);
        // destination offset wraps downward
        run_move(8'h44, 8'h00, 16'h0220, 8'h03, 8'h01, 16'd2, 16'h0030, 16'h0001);
        // single byte: A = 0
        run_move(8'h54, 8'h00, 16'h0140, 8'h03, 8'h02, 16'd0, 16'h0090, 16'h00A0);
        // bank operands swapped roles
        run_move(8'h44, 8'h00, 16'h0160, 8'h01, 8'h03, 16'd1, 16'h00C0, 16'h00E0);

        @(negedge clk);
        chk("R8", "done after final pass", done, 0);
        chk("R1", "idle after move", busy, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule